// File: doc/BRIEF.md
# System configuration register bank

This block is the software-visible register file of a microcontroller's system configuration controller. It decodes a 1 KB window on a simple strobe-based register bus. It holds eleven 32-bit word locations:

- a memory-remap selector;
- two configuration words;
- four external-interrupt source-select words;
- an SRAM control word;
- two SRAM write-protect words;
- a key word.

Every stored value is driven out as a plain output, so that neighbouring logic can act on it. The remapping, erase, firewall and parity hardware are not part of this block.

Each location has its own write rule:

- Some bits simply take the written value, under a per-register mask.
- One configuration bit can only be cleared by software.
- Four lock bits can only be set.
- An error flag is cleared by writing one to it. A hardware event input also sets this flag.
- The write-protect words accumulate every value written to them.

The bus uses a write strobe and a read strobe. A write takes effect at the clock edge that samples it. Read data is registered and appears in the cycle after the read strobe.

Top module: `sysconf_regbank`

## Requirements
- R1: After reset, cfg1_q reads 0x7C000001 and every other register (remap, the four selects, SRAM control, cfg2, both write-protect words, key) reads 0.
- R2: A write to offset 0x00 stores wdata AND 0x00000107. A write to offset 0x08, 0x0C, 0x10 or 0x14 stores wdata AND 0x0000FFFF. These four select words appear in exti_sel_q as 16-bit fields, with offset 0x08 in bits [15:0], 0x0C in [31:16], 0x10 in [47:32] and 0x14 in [63:48]. A write to offset 0x24 stores wdata AND 0x000000FF.
- R3: A write to offset 0x04 sets config 1 to (wdata AND 0xFCFF0100) OR (old bit 0 AND wdata bit 0). Bit 0 is therefore never set again except by reset.
- R4: Bits [3:0] of config 2 (offset 0x1C) are lock bits. Writing 1 sets a lock bit, writing 0 leaves it unchanged, and only reset clears it.
- R5: Bit 8 of config 2 is an error flag. Writing 1 to bit 8 clears it and writing 0 leaves it unchanged. All other config 2 bits read 0.
- R6: When parity_err_set is high at a clock edge, the error flag is 1 after that edge, even if a write in the same cycle clears it.
- R7: A write to offset 0x20 or 0x28 ORs wdata into that write-protect word. Its bits clear only on reset.
- R8: Writes to the SRAM control word at offset 0x18 are ignored, and it always reads 0.
- R9: A read at an unmapped offset (0x2C and above) or a misaligned offset (addr[1:0] not 0) returns 0. A write at such an offset changes no register.
- R10: A register output changes at the clock edge where its write strobe is sampled. rdata shows the addressed value, as it was before that edge, from the edge that samples rd_en. rdata holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset within the window |
| wdata | input | 32 | Write data |
| parity_err_set | input | 1 | Hardware event that sets the config 2 error flag |
| rdata | output | 32 | Registered read data |
| remap_q | output | 32 | Memory-remap word |
| cfg1_q | output | 32 | Config 1 word |
| exti_sel_q | output | 64 | Four 16-bit source-select fields |
| cfg2_q | output | 32 | Config 2 word (locks in [3:0], flag in bit 8) |
| wprot1_q | output | 32 | Write-protect word 1 |
| key_q | output | 32 | Key word |
| wprot2_q | output | 32 | Write-protect word 2 |

## Verification
The bench goes after the following corner cases:

- **Rewriting 1 to config 1 bit 0 after it has been cleared.** A design that simply stored the value would set the bit back to 1.
- **Writing zeros over set lock bits and over the write-protect words.** A design that got these wrong would drop protections that software believed were held.
- **A hardware set colliding with a software clear of the error flag.** A design with the wrong priority would lose an error event.
- **Writes at misaligned and unmapped offsets, and writes to SRAM control.** A design with loose address decoding would alias these onto real registers or return stale data.

All of these cases are mixed into a seeded random stream of writes and reads, which is checked against a register model kept in the bench.

// File: rtl/sysconf_regbank.sv
module sysconf_regbank #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              parity_err_set,
  output logic [31:0]       rdata,
  output logic [31:0]       remap_q,
  output logic [31:0]       cfg1_q,
  output logic [63:0]       exti_sel_q,
  output logic [31:0]       cfg2_q,
  output logic [31:0]       wprot1_q,
  output logic [31:0]       key_q,
  output logic [31:0]       wprot2_q
);
  localparam int WORDS = 11;
  localparam int NSEL  = 4;
  localparam int IW    = ADDR_W - 2;
  localparam logic [31:0] M_REMAP = 32'h0000_0107;
  localparam logic [31:0] M_CFG1  = 32'hFCFF_0100;
  localparam logic [31:0] M_KEY   = 32'h0000_00FF;
  localparam logic [31:0] CFG1_RST = 32'h7C00_0001;

  logic [WORDS-1:0] hit, wr;
  logic [IW-1:0]    widx;
  logic             aligned;
  logic [3:0]       lock_r;
  logic             flag_r;
  logic [31:0]      rd_mux;
  logic [15:0]      sel_r [NSEL];

  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = addr[ADDR_W-1:2];

  for (genvar i = 0; i < WORDS; i++) begin : g_dec
    assign hit[i] = aligned && (widx == IW'(i));
  end
  assign wr = hit & {WORDS{wr_en}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     remap_q <= '0;
    else if (wr[0]) remap_q <= wdata & M_REMAP;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cfg1_q <= CFG1_RST;
    else if (wr[1]) cfg1_q <= (wdata & M_CFG1) | {31'b0, cfg1_q[0] & wdata[0]};

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       sel_r[i] <= '0;
      else if (wr[2+i]) sel_r[i] <= wdata[15:0];
    assign exti_sel_q[16*i +: 16] = sel_r[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_r <= '0;
      flag_r <= 1'b0;
    end else begin
      if (wr[7]) lock_r <= lock_r | wdata[3:0];
      flag_r <= parity_err_set | (flag_r & ~(wr[7] & wdata[8]));
    end
  assign cfg2_q = {23'b0, flag_r, 4'b0, lock_r};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     wprot1_q <= '0;
    else if (wr[8]) wprot1_q <= wprot1_q | wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     key_q <= '0;
    else if (wr[9]) key_q <= wdata & M_KEY;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wprot2_q <= '0;
    else if (wr[10]) wprot2_q <= wprot2_q | wdata;

  always_comb begin
    rd_mux = '0;
    if (aligned)
      case (widx)
        IW'(0):  rd_mux = remap_q;
        IW'(1):  rd_mux = cfg1_q;
        IW'(2):  rd_mux = {16'b0, sel_r[0]};
        IW'(3):  rd_mux = {16'b0, sel_r[1]};
        IW'(4):  rd_mux = {16'b0, sel_r[2]};
        IW'(5):  rd_mux = {16'b0, sel_r[3]};
        IW'(7):  rd_mux = cfg2_q;
        IW'(8):  rd_mux = wprot1_q;
        IW'(9):  rd_mux = key_q;
        IW'(10): rd_mux = wprot2_q;
        default: rd_mux = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
endmodule

module sysconf_regbank_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              parity_err_set,
  input logic [31:0]       rdata,
  input logic [31:0]       remap_q,
  input logic [31:0]       cfg1_q,
  input logic [31:0]       cfg2_q,
  input logic [31:0]       wprot1_q,
  input logic [31:0]       wprot2_q
);
  p_cfg1_bit0_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cfg1_q[0]));
  p_lock_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg2_q[3:0]) & ~cfg2_q[3:0]) == 4'b0));
  p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_set |=> cfg2_q[8]);
  p_wprot_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(wprot1_q) & ~wprot1_q) | ($past(wprot2_q) & ~wprot2_q)) == 32'b0));
  p_misaligned_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] != 2'b00) |=> (rdata == 32'b0));
  p_sram_ctrl_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(32'h18)) |=> (rdata == 32'b0));
  p_remap_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> (remap_q == ($past(wdata) & 32'h107)));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind sysconf_regbank sysconf_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .parity_err_set(parity_err_set), .rdata(rdata),
  .remap_q(remap_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q),
  .wprot1_q(wprot1_q), .wprot2_q(wprot2_q)
);

// File: tb/sysconf_regbank_tb_top.sv
module sysconf_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, parity_err_set = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, remap_q, cfg1_q, cfg2_q, wprot1_q, key_q, wprot2_q;
  logic [63:0] exti_sel_q;

  int checks = 0, failures = 0;
  logic [31:0] m_remap, m_cfg1, m_cfg2, m_wp1, m_key, m_wp2;
  logic [15:0] m_sel [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysconf_regbank #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .parity_err_set(parity_err_set), .rdata(rdata),
    .remap_q(remap_q), .cfg1_q(cfg1_q), .exti_sel_q(exti_sel_q),
    .cfg2_q(cfg2_q), .wprot1_q(wprot1_q), .key_q(key_q), .wprot2_q(wprot2_q));

  function automatic string req_of(logic [ADDR_W-1:0] a);
    if (a[1:0] != 0 || a >= 10'h2C) return "R9";
    case (a)
      10'h04: return "R3";
      10'h18: return "R8";
      10'h1C: return "R5";
      10'h20, 10'h28: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      10'h00: return m_remap;
      10'h04: return m_cfg1;
      10'h08: return {16'b0, m_sel[0]};
      10'h0C: return {16'b0, m_sel[1]};
      10'h10: return {16'b0, m_sel[2]};
      10'h14: return {16'b0, m_sel[3]};
      10'h1C: return m_cfg2;
      10'h20: return m_wp1;
      10'h24: return m_key;
      10'h28: return m_wp2;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_remap = 0; m_cfg1 = 32'h7C000001; m_cfg2 = 0; m_wp1 = 0; m_key = 0; m_wp2 = 0;
    for (int i = 0; i < 4; i++) m_sel[i] = 0;
  endtask

  task automatic model_write(logic [ADDR_W-1:0] a, logic [31:0] d, logic hw);
    logic flag;
    flag = m_cfg2[8];
    if (a[1:0] == 0)
      case (a)
        10'h00: m_remap = d & 32'h107;
        10'h04: m_cfg1 = (d & 32'hFCFF0100) | {31'b0, m_cfg1[0] & d[0]};
        10'h08: m_sel[0] = d[15:0];
        10'h0C: m_sel[1] = d[15:0];
        10'h10: m_sel[2] = d[15:0];
        10'h14: m_sel[3] = d[15:0];
        10'h1C: begin m_cfg2[3:0] = m_cfg2[3:0] | d[3:0]; if (d[8]) flag = 0; end
        10'h20: m_wp1 = m_wp1 | d;
        10'h24: m_key = d & 32'hFF;
        10'h28: m_wp2 = m_wp2 | d;
        default: ;
      endcase
    m_cfg2[8] = flag | hw;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check(req, remap_q, m_remap, "remap_q");
    check(req, cfg1_q, m_cfg1, "cfg1_q");
    check(req, exti_sel_q[31:0], {m_sel[1], m_sel[0]}, "sel_lo");
    check(req, exti_sel_q[63:32], {m_sel[3], m_sel[2]}, "sel_hi");
    check(req, cfg2_q, m_cfg2, "cfg2_q");
    check(req, wprot1_q, m_wp1, "wprot1_q");
    check(req, key_q, m_key, "key_q");
    check(req, wprot2_q, m_wp2, "wprot2_q");
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d, logic hw);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; parity_err_set = hw;
    @(negedge clk);
    wr_en = 0; parity_err_set = 0;
    model_write(a, d, hw);
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check(req, rdata, exp_read(a), "rdata");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] alist [14];
    logic [31:0] seed;
    seed = $urandom(32'h5A17);
    alist = '{10'h00, 10'h04, 10'h08, 10'h0C, 10'h10, 10'h14, 10'h18,
              10'h1C, 10'h20, 10'h24, 10'h28, 10'h2C, 10'h3FC, 10'h06};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_outputs("R1");
    for (int i = 0; i < 11; i++) do_read(alist[i], "R1");

    // R10: write visible right after its edge; read data a cycle after the strobe
    do_write(10'h00, 32'hFFFFFFFF, 0);
    check("R10", remap_q, 32'h107, "remap after write edge");
    do_read(10'h00, "R10");
    // R10: rdata holds while rd_en low
    @(negedge clk); check("R10", rdata, 32'h107, "rdata hold");

    // R3: clear bit 0, then writing 1 does not restore it
    do_write(10'h04, 32'h0, 0);
    check("R3", cfg1_q, 32'h0, "cfg1 cleared");
    do_write(10'h04, 32'hFFFFFFFF, 0);
    check("R3", cfg1_q, 32'hFCFF0100, "cfg1 bit0 stays clear");

    // R4: lock bits set-only
    do_write(10'h1C, 32'h5, 0);
    do_write(10'h1C, 32'h0, 0);
    check("R4", cfg2_q, 32'h5, "locks kept");
    do_write(10'h1C, 32'hA, 0);
    check("R4", cfg2_q, 32'hF, "locks accumulated");

    // R6 and R5: hw set, write 0 keeps flag, W1C clears, set beats clear
    do_write(10'h1C, 32'h0, 1);
    check("R6", cfg2_q, 32'h10F, "hw set");
    do_write(10'h1C, 32'h0, 0);
    check("R5", cfg2_q, 32'h10F, "write 0 keeps flag");
    do_write(10'h1C, 32'h100, 1);
    check("R6", cfg2_q, 32'h10F, "set wins over clear");
    do_write(10'h1C, 32'h100, 0);
    check("R5", cfg2_q, 32'h00F, "w1c clears");

    // R7: accumulate, zeros do not clear
    do_write(10'h20, 32'h00F0, 0);
    do_write(10'h20, 32'h0, 0);
    do_write(10'h28, 32'h8000_0001, 0);
    check("R7", wprot1_q, 32'h00F0, "wprot1 kept");
    check("R7", wprot2_q, 32'h8000_0001, "wprot2 set");

    // R8 and R9: ignored writes, zero reads
    do_write(10'h18, 32'hFFFFFFFF, 0);
    do_read(10'h18, "R8");
    check_outputs("R8");
    do_write(10'h05, 32'hFFFFFFFF, 0);
    do_write(10'h2C, 32'hFFFFFFFF, 0);
    do_write(10'h3FC, 32'hFFFFFFFF, 0);
    check_outputs("R9");
    do_read(10'h01, "R9");
    do_read(10'h30, "R9");

    for (int n = 0; n < 600; n++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      logic hw;
      a = alist[$urandom_range(0, 13)];
      d = $urandom();
      hw = ($urandom_range(0, 7) == 0);
      do_write(a, d, hw);
      check_outputs(req_of(a));
      do_read(alist[$urandom_range(0, 13)], "R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule